// File: doc/BRIEF.md
# CAN Transmit Slot Scheduler

This block keeps track of a pool of transmit slots for a CAN controller and decides which slot the protocol engine sends next. The pool holds a set of dedicated buffers followed by a transmit FIFO region, with at most 32 slots in total. Software marks a dedicated buffer ready by pulsing its add bit. It queues a FIFO frame by writing the identifier at the slot index the block reports as the put position, then pulsing the FIFO add input. Each slot's 11-bit identifier (or a wider one, set by a parameter) is presented continuously on a flat input vector.

The scheduler presents the winning slot and a valid flag. Among pending dedicated buffers, the lowest identifier wins. An identifier tie goes to the lower buffer number. Only the oldest FIFO entry takes part in the comparison, so FIFO frames always leave in the order they were queued. When the engine takes the offered slot, that slot is locked until the engine reports done or failed. Done retires the slot, sets its transmission-occurred bit and pulses its completion interrupt if that interrupt is enabled. Failed returns the slot to arbitration. A cancel removes a pending dedicated buffer unless that buffer is the one on the bus.

Top module: `can_tx_sched`

## Requirements
- R1: After reset no slot is pending, no transmission-occurred or interrupt bit is set, `sel_valid_o` is low, the FIFO is not full and `fifo_put_o` equals NUM_BUF, the first FIFO slot.
- R2: A pulse on bit b of `buf_add_i` sets bit b of `pend_o` at the next clock edge, and `sel_valid_o` rises in that cycle if no transmission is in progress.
- R3: Among pending dedicated buffers and the FIFO head, `sel_idx_o` names the slot with the numerically lowest identifier.
- R4: When several pending dedicated buffers share the lowest identifier, the lowest buffer number is selected.
- R5: FIFO slots occupy indices NUM_BUF to NUM_BUF+FIFO_DEPTH-1 and are filled in ascending order with wrap-around. Only the oldest queued entry competes, so FIFO entries are sent in queue order whatever their identifiers.
- R6: A FIFO add while the FIFO is full is rejected: `fifo_full_o` is high, and `pend_o` and `fifo_put_o` are unchanged.
- R7: `tx_start_i` while `sel_valid_o` is high locks the offered slot and drops `sel_valid_o` until the end of the transmission. `tx_done_i` then clears that slot's pending bit and sets its bit in `txo_o` at the next edge.
- R8: The done edge raises bit s of `irq_o` for exactly one cycle when bit s of `irq_en_i` is set, and leaves `irq_o` low when it is clear.
- R9: `tx_fail_i` keeps the locked slot pending, ends the transmission, and lets the slot be offered again.
- R10: Bit b of `cancel_i` clears the pending bit of dedicated buffer b, except while buffer b is being transmitted, when the cancel has no effect.
- R11: Adding a slot again clears its transmission-occurred bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_add_i | input | NUM_BUF | Per-buffer add request pulses |
| fifo_add_i | input | 1 | Queue the frame at the FIFO put slot |
| slot_id_i | input | NS*ID_W | Identifier of every slot, slot s at bits s*ID_W upward |
| cancel_i | input | NUM_BUF | Per-buffer cancel request pulses |
| irq_en_i | input | NS | Per-slot completion interrupt enables |
| tx_start_i | input | 1 | Engine takes the offered slot |
| tx_done_i | input | 1 | Locked slot sent successfully |
| tx_fail_i | input | 1 | Locked slot lost arbitration or errored |
| sel_valid_o | output | 1 | A slot is offered |
| sel_idx_o | output | IW | Offered slot index |
| pend_o | output | NS | Pending bitmap |
| txo_o | output | NS | Transmission-occurred bitmap |
| irq_o | output | NS | One-cycle completion interrupt per slot |
| fifo_full_o | output | 1 | FIFO region full |
| fifo_put_o | output | IW | Slot index the next FIFO add will use |

## Verification
Every state change is registered once. An add or cancel shows up on `pend_o` and `sel_*` one edge after the pulse. A start drops `sel_valid_o` one edge after it is sampled. A done or fail updates `pend_o`, `txo_o` and `irq_o` at the next edge, and the interrupt is gone again one edge later. The bench drives each pulse for one edge only and samples 2 ns after that edge, so each result is read in exactly the cycle it is due. The winner is checked against an arithmetic model over every nonempty subset of pending buffers, for both distinct and equal identifiers.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  localparam int unsigned MAX_SLOTS = 32;
  typedef enum logic { ST_IDLE, ST_BUSY } tx_state_e;
endpackage

// File: rtl/can_tx_fifo_ptr.sv
module can_tx_fifo_ptr #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          push_ok_o,
  output logic [PW-1:0] get_o,
  output logic [PW-1:0] put_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [PW-1:0] get_q, put_q;
  logic [CW-1:0] cnt_q;
  logic pop_ok;

  assign full_o    = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);
  assign push_ok_o = push_i & ~full_o;
  assign pop_ok    = pop_i & ~empty_o;
  assign get_o     = get_q;
  assign put_o     = put_q;

  function automatic logic [PW-1:0] wrap_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      get_q <= '0;
      put_q <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok_o) put_q <= wrap_inc(put_q);
      if (pop_ok)    get_q <= wrap_inc(get_q);
      if (push_ok_o && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (!push_ok_o && pop_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_FIFO_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)) else $error("fifo count overflow"); // R6
  AST_FULL_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(put_q)) else $error("push into full fifo"); // R6
endmodule

// File: rtl/can_tx_pick.sv
module can_tx_pick #(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned NS      = 8,
  parameter int unsigned ID_W    = 11,
  parameter int unsigned IW      = 3
) (
  input  logic [NS-1:0]      pend_i,
  input  logic [NS*ID_W-1:0] id_i,
  input  logic               head_vld_i,
  input  logic [IW-1:0]      head_i,
  output logic               vld_o,
  output logic [IW-1:0]      idx_o,
  output logic [ID_W-1:0]    id_o
);
  logic [ID_W-1:0] head_id;
  assign head_id = id_i[int'(head_i)*ID_W +: ID_W];

  // ascending scan with strict compare keeps the lower index on a tie
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    id_o  = '1;
    for (int b = 0; b < int'(NUM_BUF); b++) begin
      if (pend_i[b] && (!vld_o || id_i[b*ID_W +: ID_W] < id_o)) begin
        vld_o = 1'b1;
        idx_o = IW'(b);
        id_o  = id_i[b*ID_W +: ID_W];
      end
    end
    if (head_vld_i && pend_i[head_i] && (!vld_o || head_id < id_o)) begin
      vld_o = 1'b1;
      idx_o = head_i;
      id_o  = head_id;
    end
  end
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_tx_pkg::*;
#(
  parameter int unsigned NUM_BUF    = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned ID_W       = 11,
  localparam int unsigned NS = NUM_BUF + FIFO_DEPTH,
  localparam int unsigned IW = $clog2(NS),
  localparam int unsigned PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BUF-1:0] buf_add_i,
  input  logic               fifo_add_i,
  input  logic [NS*ID_W-1:0] slot_id_i,
  input  logic [NUM_BUF-1:0] cancel_i,
  input  logic [NS-1:0]      irq_en_i,
  input  logic               tx_start_i,
  input  logic               tx_done_i,
  input  logic               tx_fail_i,
  output logic               sel_valid_o,
  output logic [IW-1:0]      sel_idx_o,
  output logic [NS-1:0]      pend_o,
  output logic [NS-1:0]      txo_o,
  output logic [NS-1:0]      irq_o,
  output logic               fifo_full_o,
  output logic [IW-1:0]      fifo_put_o
);
  initial AST_CFG: assert (NS <= MAX_SLOTS && NUM_BUF >= 1 && FIFO_DEPTH >= 2)
    else $error("slot configuration out of range"); // R5

  tx_state_e       st_q;
  logic [IW-1:0]   act_q;
  logic [NS-1:0]   pend_q, txo_q, irq_q;
  logic [NS-1:0]   act_mask, set_v, clr_v, done_v;
  logic            push_ok, fifo_empty, pop, pick_vld, busy;
  logic [PW-1:0]   get_p, put_p;
  logic [IW-1:0]   head_slot, put_slot, pick_idx;
  logic [ID_W-1:0] pick_id;

  assign busy      = (st_q == ST_BUSY);
  assign head_slot = IW'(NUM_BUF) + IW'(get_p);
  assign put_slot  = IW'(NUM_BUF) + IW'(put_p);
  assign pop       = busy && tx_done_i && (act_q >= IW'(NUM_BUF));

  can_tx_fifo_ptr #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (fifo_add_i),
    .pop_i     (pop),
    .push_ok_o (push_ok),
    .get_o     (get_p),
    .put_o     (put_p),
    .full_o    (fifo_full_o),
    .empty_o   (fifo_empty)
  );

  can_tx_pick #(.NUM_BUF(NUM_BUF), .NS(NS), .ID_W(ID_W), .IW(IW)) u_pick (
    .pend_i     (pend_q),
    .id_i       (slot_id_i),
    .head_vld_i (~fifo_empty),
    .head_i     (head_slot),
    .vld_o      (pick_vld),
    .idx_o      (pick_idx),
    .id_o       (pick_id)
  );

  always_comb begin
    act_mask = busy ? (NS'(1) << act_q) : '0;
    done_v   = (busy && tx_done_i) ? (NS'(1) << act_q) : '0;
    set_v    = '0;
    set_v[NUM_BUF-1:0] = buf_add_i;
    if (push_ok) set_v[put_slot] = 1'b1;
    set_v    = set_v & ~act_mask;
    clr_v    = (NS'(cancel_i) & ~act_mask) | done_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      act_q  <= '0;
      pend_q <= '0;
      txo_q  <= '0;
      irq_q  <= '0;
    end else begin
      pend_q <= (pend_q | set_v) & ~clr_v;
      txo_q  <= (txo_q & ~set_v) | done_v;
      irq_q  <= done_v & irq_en_i;
      case (st_q)
        ST_IDLE: if (tx_start_i && pick_vld) begin
          st_q  <= ST_BUSY;
          act_q <= pick_idx;
        end
        ST_BUSY: if (tx_done_i || tx_fail_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sel_valid_o = pick_vld && !busy;
  assign sel_idx_o   = pick_idx;
  assign pend_o      = pend_q;
  assign txo_o       = txo_q;
  assign irq_o       = irq_q;
  assign fifo_put_o  = put_slot;

  AST_SEL_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> pend_q[sel_idx_o]) else $error("offered slot not pending"); // R2
  for (genvar b = 0; b < NUM_BUF; b++) begin : g_arb_chk
    AST_LOWEST_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_valid_o && pend_q[b]) |-> (pick_id <= slot_id_i[b*ID_W +: ID_W]))
      else $error("higher id won"); // R3
    AST_TIE_LOW_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_valid_o && pend_q[b] && pick_id == slot_id_i[b*ID_W +: ID_W]) |-> (sel_idx_o <= IW'(b)))
      else $error("tie not to lowest buffer"); // R4
  end
  AST_ACTIVE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> pend_q[act_q]) else $error("active slot lost pending"); // R10
  AST_DONE_TXO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tx_done_i) |=> txo_q[$past(act_q)]) else $error("done without txo"); // R7
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q != '0) |-> $past(busy && tx_done_i)) else $error("stray irq"); // R8
  AST_IRQ_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_q)) else $error("multiple irq bits"); // R8
endmodule

// File: tb/sim_can_tx_sched.sv
module sim_can_tx_sched;
  localparam int NB = 4, FD = 4, IDW = 11, NS = 8, IW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NB-1:0] buf_add_i = '0, cancel_i = '0;
  logic fifo_add_i = 1'b0, tx_start_i = 1'b0, tx_done_i = 1'b0, tx_fail_i = 1'b0;
  logic [NS-1:0] irq_en_i = '0;
  logic [NS*IDW-1:0] slot_id_i;
  logic sel_valid_o, fifo_full_o;
  logic [IW-1:0] sel_idx_o, fifo_put_o;
  logic [NS-1:0] pend_o, txo_o, irq_o;
  logic [IDW-1:0] ids [NS];

  int nchk = 0, nbad = 0;
  int m_head = 0, m_cnt = 0, m_put = 0;
  logic [NS-1:0] m_pend = '0;
  bit ended = 0;

  always #4 clk = ~clk;

  always_comb for (int s = 0; s < NS; s++) slot_id_i[s*IDW +: IDW] = ids[s];

  can_tx_sched #(.NUM_BUF(NB), .FIFO_DEPTH(FD), .ID_W(IDW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .buf_add_i(buf_add_i), .fifo_add_i(fifo_add_i),
    .slot_id_i(slot_id_i), .cancel_i(cancel_i), .irq_en_i(irq_en_i),
    .tx_start_i(tx_start_i), .tx_done_i(tx_done_i), .tx_fail_i(tx_fail_i),
    .sel_valid_o(sel_valid_o), .sel_idx_o(sel_idx_o), .pend_o(pend_o), .txo_o(txo_o),
    .irq_o(irq_o), .fifo_full_o(fifo_full_o), .fifo_put_o(fifo_put_o));

  task automatic chk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    buf_add_i = '0; cancel_i = '0; fifo_add_i = 0;
    tx_start_i = 0; tx_done_i = 0; tx_fail_i = 0;
  endtask

  // reference winner: lowest id, ascending buffers, then fifo head
  task automatic chk_sel(string r);
    bit v = 0; int e = 0; int best = 0;
    for (int b = 0; b < NB; b++)
      if (m_pend[b] && (!v || int'(ids[b]) < best)) begin v = 1; e = b; best = int'(ids[b]); end
    if (m_cnt > 0 && (!v || int'(ids[NB+m_head]) < best)) begin v = 1; e = NB + m_head; end
    chk({r, " valid"}, int'(sel_valid_o), int'(v));
    if (v) chk({r, " idx"}, int'(sel_idx_o), e);
  endtask

  task automatic push(logic [IDW-1:0] id);
    ids[NB+m_put] = id;
    fifo_add_i = 1; tick();
    m_pend[NB+m_put] = 1; m_put = (m_put + 1) % FD; m_cnt++;
  endtask

  task automatic sweep(string r);
    for (int mask = 1; mask < 16; mask++) begin
      cancel_i = '1; tick(); m_pend[NB-1:0] = '0;
      buf_add_i = NB'(mask); tick(); m_pend[NB-1:0] = NB'(mask);
      chk("R2 pend", int'(pend_o), int'(m_pend));
      chk_sel(r);
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++) ids[s] = '0;
    repeat (3) @(posedge clk);
    #2 rst_ni = 1;
    chk("R1 pend", int'(pend_o), 0);
    chk("R1 txo", int'(txo_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 valid", int'(sel_valid_o), 0);
    chk("R1 full", int'(fifo_full_o), 0);
    chk("R1 put", int'(fifo_put_o), NB);

    ids[0] = 11'h120; ids[1] = 11'h050; ids[2] = 11'h050; ids[3] = 11'h300;
    sweep("R3");
    for (int b = 0; b < NB; b++) ids[b] = 11'h2AA;
    sweep("R4");
    cancel_i = '1; tick(); m_pend = '0;

    push(11'h700); push(11'h010); push(11'h020); push(11'h030);
    chk("R6 full", int'(fifo_full_o), 1);
    chk("R5 put wrap", int'(fifo_put_o), NB);
    chk_sel("R5 head only");
    fifo_add_i = 1; tick();
    chk("R6 pend kept", int'(pend_o), int'(m_pend));
    chk("R6 put kept", int'(fifo_put_o), NB);

    irq_en_i = 8'h04;
    buf_add_i = 4'b0100; tick(); m_pend[2] = 1;
    chk_sel("R3 buf vs head");
    tx_start_i = 1; tick();
    chk("R7 locked", int'(sel_valid_o), 0);
    tx_done_i = 1; tick(); m_pend[2] = 0;
    chk("R7 pend", int'(pend_o), int'(m_pend));
    chk("R7 txo", int'(txo_o[2]), 1);
    chk("R8 irq", int'(irq_o), 8'h04);
    tick();
    chk("R8 irq pulse", int'(irq_o), 0);

    for (int k = 0; k < FD; k++) begin
      chk_sel("R5 order");
      tx_start_i = 1; tick();
      tx_done_i = 1; tick();
      m_pend[NB+m_head] = 0; m_head = (m_head + 1) % FD; m_cnt--;
      chk("R7 fifo txo", int'(txo_o[NB+k]), 1);
      chk("R8 irq masked", int'(irq_o), 0);
    end
    chk("R5 drained", int'(sel_valid_o), 0);
    push(11'h001);
    chk("R5 put next", int'(fifo_put_o), NB + 1);
    chk_sel("R5 refill");
    tx_start_i = 1; tick();
    tx_done_i = 1; tick();
    m_pend[NB+m_head] = 0; m_head = (m_head + 1) % FD; m_cnt--;

    buf_add_i = 4'b0010; tick(); m_pend[1] = 1;
    tx_start_i = 1; tick();
    tx_fail_i = 1; tick();
    chk("R9 pend", int'(pend_o[1]), 1);
    chk_sel("R9 reoffer");
    chk("R9 irq", int'(irq_o), 0);
    tx_start_i = 1; tick();
    cancel_i = 4'b0010; tick();
    chk("R10 active kept", int'(pend_o[1]), 1);
    tx_done_i = 1; tick(); m_pend[1] = 0;
    chk("R10 done", int'(pend_o), 0);
    chk("R7 txo1", int'(txo_o[1]), 1);
    chk("R8 irq off", int'(irq_o), 0);
    buf_add_i = 4'b0010; tick(); m_pend[1] = 1;
    chk("R11 txo cleared", int'(txo_o[1]), 0);
    cancel_i = 4'b0010; tick(); m_pend[1] = 0;
    chk("R10 cancel", int'(pend_o), 0);
    chk("R10 no sel", int'(sel_valid_o), 0);

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!ended) begin
      ended = 1;
      nchk++; nbad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule